// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the 8-bit execute stage of a small accumulator-style processor core. One operand is always the working register. The other is either a byte read from the data-memory register file or an immediate literal from the instruction. The block adds (with or without the stored carry), subtracts (with or without the stored borrow), rotates through carry, applies bitwise AND, OR and XOR, or passes the operand through. It keeps its own five-flag status register, and it signals whether the result goes back to the working register or to the file register.

Instruction decode presents an opcode, the operands, an operand-select bit, a destination bit and a one-cycle execute strobe. On the clock edge that samples the strobe, the block registers the result, pulses exactly one of two write-target strobes and updates the flags. The surrounding core stores the result into the chosen register. Because the carry input comes from the block's own flag register, multi-byte arithmetic chains from one instruction to the next without help from outside.

Top module: `acc_alu_core`

## Requirements
- R1: After reset, res_val is 0x00, wr_wreg and wr_file are 0, and flags (bit 0 C, bit 1 DC, bit 2 Z, bit 3 OV, bit 4 N) is 0b00000.
- R2: Opcode 0 (add) gives operand + wreg. C is the carry out of bit 7, DC is the carry from bit 3 into bit 4, OV is set when the signed sum falls outside -128..127, Z is set when the result is 0x00, and N is result bit 7. Example: wreg 0x9F plus operand 0x52 gives 0xF1 with N=1, OV=0, Z=0, C=0, DC=1.
- R3: Opcode 1 (add with carry) gives operand + wreg + C, with flags as in R2. A low-byte add followed by this opcode adds two-byte values correctly.
- R4: Opcode 2 (subtract) gives operand - wreg, and opcode 3 gives operand - wreg - C. C is 1 when the full difference borrows. DC is 1 when the low nibble borrows. OV is set when the signed difference falls outside -128..127. Z and N are as in R2.
- R5: Opcodes 4 (AND), 5 (OR) and 6 (XOR) combine operand with wreg. They update only Z and N and leave C, DC and OV unchanged.
- R6: Opcode 7 rotates the operand left through carry: result bit 0 takes the old C and the new C takes operand bit 7. Opcode 8 rotates right: result bit 7 takes the old C and the new C takes operand bit 0. Z and N update, and DC and OV are unchanged.
- R7: When use_lit is 1 the operand is lit_val, and when it is 0 the operand is file_val.
- R8: An execute with dest_sel 0 pulses wr_wreg, and with dest_sel 1 pulses wr_file. The pulse appears in the cycle after the sampling edge, together with the new res_val and flags. At most one strobe is high in any cycle.
- R9: With exec_en low, or with a reserved opcode (10 to 15), no strobe rises, flags stay the same and res_val keeps its value.
- R10: Opcode 9 (move) passes the operand to the result unchanged. It updates Z and N and leaves C, DC and OV unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec_en | input | 1 | Execute strobe, sampled on the rising edge |
| op_code | input | 4 | Operation select (codes 0..9, others reserved) |
| wreg_val | input | 8 | Working-register operand |
| file_val | input | 8 | File-register operand |
| lit_val | input | 8 | Immediate literal operand |
| use_lit | input | 1 | 1 selects lit_val, 0 selects file_val |
| dest_sel | input | 1 | 0 targets the working register, 1 the file register |
| res_val | output | 8 | Registered result |
| wr_wreg | output | 1 | Write strobe for the working register |
| wr_file | output | 1 | Write strobe for the file register |
| flags | output | 5 | Status register {N, OV, Z, DC, C} |

## Verification
Every result of this block (res_val, the write-target strobe and all five flags) is due one clock edge after the edge that samples exec_en, since each passes through exactly one register. The bench drives inputs on the falling edge, holds the strobe for one rising edge, and compares all outputs on the next falling edge. Its reference model tracks the expected flag register across operations, so carry chaining and preserved flags are checked against the bench's own history. For the idle and reserved-opcode cases, the bench samples one more falling edge after the strobe and confirms that the strobes are low and that the result and flags have not moved.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int unsigned FLAG_W = 5;

  // bit positions inside the status register
  localparam int unsigned FB_C  = 0;
  localparam int unsigned FB_DC = 1;
  localparam int unsigned FB_Z  = 2;
  localparam int unsigned FB_OV = 3;
  localparam int unsigned FB_N  = 4;

  typedef struct packed {
    logic n;
    logic ov;
    logic z;
    logic dc;
    logic c;
  } flags_t;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBB = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_RLC  = 4'd7,
    OP_RRC  = 4'd8,
    OP_MOVE = 4'd9
  } alu_op_e;

  function automatic logic op_is_arith(input logic [3:0] op);
    return (op <= 4'd3);
  endfunction

  function automatic logic op_is_bitwise(input logic [3:0] op);
    return (op == 4'd4) || (op == 4'd5) || (op == 4'd6) || (op == 4'd9);
  endfunction

  function automatic logic op_is_rotate(input logic [3:0] op);
    return (op == 4'd7) || (op == 4'd8);
  endfunction

  function automatic logic op_is_valid(input logic [3:0] op);
    return (op <= 4'd9);
  endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] opnd,
  input  logic [W-1:0] wreg,
  input  logic         do_sub,
  input  logic         use_cflag,
  input  logic         c_flag,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         dc_out,
  output logic         ov_out
);

  localparam int unsigned HALF = W / 2;

  // full-width and low-half sums of a + b + ci
  function automatic logic [W:0] wide_add(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic ci);
    return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
  endfunction

  function automatic logic [HALF:0] half_add(input logic [HALF-1:0] a, input logic [HALF-1:0] b,
                                             input logic ci);
    return {1'b0, a} + {1'b0, b} + {{HALF{1'b0}}, ci};
  endfunction

  logic [W-1:0]  b_eff;
  logic          ci_eff;
  logic [W:0]    full_sum;
  logic [HALF:0] low_sum;
  logic          raw_cout;
  logic          raw_hc;

  // subtraction is a + ~b + 1 (minus a pending borrow); C means borrow
  assign b_eff    = do_sub ? ~wreg : wreg;
  assign ci_eff   = do_sub ? ~(use_cflag & c_flag) : (use_cflag & c_flag);
  assign full_sum = wide_add(opnd, b_eff, ci_eff);
  assign low_sum  = half_add(opnd[HALF-1:0], b_eff[HALF-1:0], ci_eff);
  assign raw_cout = full_sum[W];
  assign raw_hc   = low_sum[HALF];

  assign sum    = full_sum[W-1:0];
  assign c_out  = do_sub ? ~raw_cout : raw_cout;
  assign dc_out = do_sub ? ~raw_hc : raw_hc;
  assign ov_out = (opnd[W-1] == b_eff[W-1]) && (sum[W-1] != opnd[W-1]);

endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops #(
  parameter int unsigned W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] opnd,
  input  logic [W-1:0] wreg,
  input  logic         c_flag,
  output logic [W-1:0] res,
  output logic         c_out
);

  import acc_alu_pkg::*;

  always_comb begin
    res   = opnd;
    c_out = c_flag;
    case (alu_op_e'(op))
      OP_AND:  res = opnd & wreg;
      OP_OR:   res = opnd | wreg;
      OP_XOR:  res = opnd ^ wreg;
      OP_RLC: begin
        res   = {opnd[W-2:0], c_flag};
        c_out = opnd[W-1];
      end
      OP_RRC: begin
        res   = {c_flag, opnd[W-1:1]};
        c_out = opnd[0];
      end
      default: res = opnd;
    endcase
  end

endmodule

// File: rtl/acc_alu_status.sv
module acc_alu_status (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd,
  input  acc_alu_pkg::flags_t   nxt,
  output acc_alu_pkg::flags_t   cur
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else if (upd) cur <= nxt;
  end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exec_en,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] wreg_val,
  input  logic [W-1:0] file_val,
  input  logic [W-1:0] lit_val,
  input  logic         use_lit,
  input  logic         dest_sel,
  output logic [W-1:0] res_val,
  output logic         wr_wreg,
  output logic         wr_file,
  output logic [4:0]   flags
);

  import acc_alu_pkg::*;

  // operand path
  logic [W-1:0] operand_sel;
  assign operand_sel = use_lit ? lit_val : file_val;

  // named decode events
  logic commit_evt;
  logic arith_evt;
  logic bitwise_evt;
  logic rotl_evt;
  logic rotr_evt;
  assign commit_evt  = exec_en && op_is_valid(op_code);
  assign arith_evt   = commit_evt && op_is_arith(op_code);
  assign bitwise_evt = commit_evt && op_is_bitwise(op_code);
  assign rotl_evt    = commit_evt && (op_code == OP_RLC);
  assign rotr_evt    = commit_evt && (op_code == OP_RRC);

  flags_t flag_q;
  flags_t flag_d;

  // arithmetic unit
  logic [W-1:0] ar_sum;
  logic         ar_c;
  logic         ar_dc;
  logic         ar_ov;

  acc_alu_arith #(.W(W)) u_arith (
    .opnd      (operand_sel),
    .wreg      (wreg_val),
    .do_sub    (op_code[1]),
    .use_cflag (op_code[0]),
    .c_flag    (flag_q.c),
    .sum       (ar_sum),
    .c_out     (ar_c),
    .dc_out    (ar_dc),
    .ov_out    (ar_ov)
  );

  // bitwise and rotate unit
  logic [W-1:0] bo_res;
  logic         bo_c;

  acc_alu_bitops #(.W(W)) u_bitops (
    .op     (op_code),
    .opnd   (operand_sel),
    .wreg   (wreg_val),
    .c_flag (flag_q.c),
    .res    (bo_res),
    .c_out  (bo_c)
  );

  // result and next-flag selection
  logic [W-1:0] res_d;

  always_comb begin
    res_d  = op_is_arith(op_code) ? ar_sum : bo_res;
    flag_d = flag_q;
    if (op_is_arith(op_code)) begin
      flag_d.c  = ar_c;
      flag_d.dc = ar_dc;
      flag_d.ov = ar_ov;
    end else if (op_is_rotate(op_code)) begin
      flag_d.c = bo_c;
    end
    flag_d.z = (res_d == '0);
    flag_d.n = res_d[W-1];
  end

  acc_alu_status u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (commit_evt),
    .nxt   (flag_d),
    .cur   (flag_q)
  );

  // registered result and write-target strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_val <= '0;
      wr_wreg <= 1'b0;
      wr_file <= 1'b0;
    end else begin
      if (commit_evt) res_val <= res_d;
      wr_wreg <= commit_evt && !dest_sel;
      wr_file <= commit_evt && dest_sel;
    end
  end

  assign flags = flag_q;

  // assertions next to the logic they guard
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_wreg, wr_file})); // R8

  AST_DEST_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (wr_file == $past(dest_sel)) && (wr_wreg == !$past(dest_sel))); // R8

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_wreg || wr_file) |-> (flags[FB_Z] == (res_val == '0))); // R2

  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_wreg || wr_file) |-> (flags[FB_N] == res_val[W-1])); // R2

  AST_LOGIC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    bitwise_evt |=> (flags[FB_C] == $past(flags[FB_C])) && (flags[FB_DC] == $past(flags[FB_DC]))
                    && (flags[FB_OV] == $past(flags[FB_OV]))); // R5

  AST_ROTL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    rotl_evt |=> (flags[FB_C] == $past(operand_sel[W-1])) && (res_val[0] == $past(flags[FB_C]))); // R6

  AST_ROTR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    rotr_evt |=> (flags[FB_C] == $past(operand_sel[0])) && (res_val[W-1] == $past(flags[FB_C]))); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(flags) && $stable(res_val) && !wr_wreg && !wr_file); // R9

endmodule

// File: tb/acc_alu_core_test.sv
module acc_alu_core_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec_en = 1'b0;
  logic [3:0] op_code = '0;
  logic [7:0] wreg_val = '0;
  logic [7:0] file_val = '0;
  logic [7:0] lit_val = '0;
  logic       use_lit = 1'b0;
  logic       dest_sel = 1'b0;
  logic [7:0] res_val;
  logic       wr_wreg;
  logic       wr_file;
  logic [4:0] flags;

  int total = 0;
  int bad = 0;
  logic [4:0] exp_flags = '0;
  logic [7:0] exp_res = '0;

  always #4 clk = ~clk;

  acc_alu_core uut (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_code(op_code),
    .wreg_val(wreg_val), .file_val(file_val), .lit_val(lit_val),
    .use_lit(use_lit), .dest_sel(dest_sel), .res_val(res_val),
    .wr_wreg(wr_wreg), .wr_file(wr_file), .flags(flags)
  );

  // entry: op[22:19] cin[18] lit[17] dest[16] wreg[15:8] operand[7:0]
  localparam int NV = 18;
  localparam logic [22:0] VEC [NV] = '{
    {4'd0, 1'b0, 1'b0, 1'b0, 8'h9F, 8'h52},
    {4'd0, 1'b1, 1'b1, 1'b1, 8'h80, 8'h80},
    {4'd0, 1'b0, 1'b0, 1'b0, 8'h01, 8'h7F},
    {4'd1, 1'b1, 1'b0, 1'b1, 8'hFF, 8'h00},
    {4'd1, 1'b0, 1'b1, 1'b0, 8'h12, 8'h34},
    {4'd2, 1'b0, 1'b0, 1'b0, 8'h07, 8'h05},
    {4'd2, 1'b1, 1'b1, 1'b1, 8'h01, 8'h80},
    {4'd3, 1'b1, 1'b0, 1'b0, 8'h0F, 8'h10},
    {4'd3, 1'b0, 1'b0, 1'b1, 8'h20, 8'h50},
    {4'd4, 1'b1, 1'b1, 1'b0, 8'h3C, 8'hF0},
    {4'd5, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00},
    {4'd6, 1'b1, 1'b0, 1'b0, 8'hAA, 8'h55},
    {4'd7, 1'b1, 1'b0, 1'b1, 8'h00, 8'h80},
    {4'd7, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h40},
    {4'd8, 1'b1, 1'b0, 1'b0, 8'h00, 8'h01},
    {4'd8, 1'b0, 1'b0, 1'b1, 8'h00, 8'h02},
    {4'd9, 1'b1, 1'b1, 1'b0, 8'h77, 8'h00},
    {4'd9, 1'b0, 1'b0, 1'b1, 8'h11, 8'hC3}
  };

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4, 4'd5, 4'd6: return "R5";
      4'd7, 4'd8: return "R6";
      4'd9: return "R10";
      default: return "R9";
    endcase
  endfunction

  function automatic int as_signed(input logic [7:0] v);
    return (v > 8'd127) ? int'(v) - 256 : int'(v);
  endfunction

  // reference model: returns {result, flags}
  function automatic logic [12:0] ref_op(input logic [3:0] op, input logic [7:0] w,
                                         input logic [7:0] b, input logic [4:0] f);
    int t;
    int lo;
    int sg;
    int k;
    logic [7:0] r;
    logic [4:0] nf;
    nf = f;
    r  = 8'h00;
    if (op == 4'd0 || op == 4'd1) begin
      k  = (op == 4'd1) ? int'(f[0]) : 0;
      t  = int'(b) + int'(w) + k;
      lo = int'(b[3:0]) + int'(w[3:0]) + k;
      sg = as_signed(b) + as_signed(w) + k;
      r  = t[7:0];
      nf[0] = (t > 255);
      nf[1] = (lo > 15);
      nf[3] = (sg > 127) || (sg < -128);
    end else if (op == 4'd2 || op == 4'd3) begin
      k  = (op == 4'd3) ? int'(f[0]) : 0;
      t  = int'(b) - int'(w) - k;
      lo = int'(b[3:0]) - int'(w[3:0]) - k;
      sg = as_signed(b) - as_signed(w) - k;
      r  = t[7:0];
      nf[0] = (t < 0);
      nf[1] = (lo < 0);
      nf[3] = (sg > 127) || (sg < -128);
    end else if (op == 4'd4) r = b & w;
    else if (op == 4'd5) r = b | w;
    else if (op == 4'd6) r = b ^ w;
    else if (op == 4'd7) begin
      r = {b[6:0], f[0]};
      nf[0] = b[7];
    end else if (op == 4'd8) begin
      r = {f[0], b[7:1]};
      nf[0] = b[0];
    end else r = b;
    nf[2] = (r == 8'h00);
    nf[4] = r[7];
    return {r, nf};
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act,
                     input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one execute: drive at falling edge, strobe one rising edge, check at next falling edge
  task automatic run_op(input logic [3:0] op, input logic [7:0] w, input logic [7:0] b,
                        input logic lit, input logic dst, input string req);
    logic [12:0] m;
    wreg_val = w;
    use_lit  = lit;
    dest_sel = dst;
    op_code  = op;
    lit_val  = lit ? b : ~b;
    file_val = lit ? ~b : b;
    exec_en  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    exec_en = 1'b0;
    m = ref_op(op, w, b, exp_flags);
    exp_res   = m[12:5];
    exp_flags = m[4:0];
    chk(req, "result", res_val, exp_res);
    chk(req, "flags", {3'b0, flags}, {3'b0, exp_flags});
    chk("R8", "target strobes", {6'b0, wr_file, wr_wreg}, {6'b0, dst, !dst});
  endtask

  task automatic preset_carry(input logic cin);
    if (cin) run_op(4'd0, 8'hFF, 8'h01, 1'b0, 1'b0, "R2");
    else     run_op(4'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R2");
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset result", res_val, 8'h00);
    chk("R1", "reset flags", {3'b0, flags}, 8'h00);
    chk("R1", "reset strobes", {6'b0, wr_file, wr_wreg}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 worked example, checked against fixed values
    run_op(4'd0, 8'h9F, 8'h52, 1'b0, 1'b0, "R2");
    chk("R2", "example sum", res_val, 8'hF1);
    chk("R2", "example flags", {3'b0, flags}, 8'b0001_0010);

    // vector table
    for (int i = 0; i < NV; i++) begin
      preset_carry(VEC[i][18]);
      run_op(VEC[i][22:19], VEC[i][15:8], VEC[i][7:0], VEC[i][17], VEC[i][16],
             req_of(VEC[i][22:19]));
    end

    // R3: two-byte chain 0x01FF + 0x0001 = 0x0200
    run_op(4'd0, 8'h01, 8'hFF, 1'b0, 1'b1, "R3");
    chk("R3", "low byte", res_val, 8'h00);
    run_op(4'd1, 8'h00, 8'h01, 1'b0, 1'b1, "R3");
    chk("R3", "high byte", res_val, 8'h02);
    chk("R3", "high carry", {7'b0, flags[0]}, 8'h00);

    // R7: operand select, same file value with literal chosen
    wreg_val = 8'h00;
    use_lit  = 1'b1;
    lit_val  = 8'h5A;
    file_val = 8'hC3;
    op_code  = 4'd9;
    dest_sel = 1'b0;
    exec_en  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    exec_en = 1'b0;
    chk("R7", "literal chosen", res_val, 8'h5A);
    use_lit = 1'b0;
    exec_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    exec_en = 1'b0;
    chk("R7", "file chosen", res_val, 8'hC3);
    exp_res   = 8'hC3;
    exp_flags = {1'b1, exp_flags[3], 1'b0, exp_flags[1:0]};
    chk("R10", "move flags", {3'b0, flags}, {3'b0, exp_flags});

    // R9: no execute, then reserved opcodes
    @(negedge clk);
    chk("R9", "strobes drop when idle", {6'b0, wr_file, wr_wreg}, 8'h00);
    op_code  = 4'd0;
    wreg_val = 8'h01;
    file_val = 8'h01;
    @(posedge clk);
    @(negedge clk);
    chk("R9", "idle result held", res_val, exp_res);
    chk("R9", "idle flags held", {3'b0, flags}, {3'b0, exp_flags});
    for (int c = 10; c < 16; c++) begin
      op_code = 4'(c);
      exec_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      exec_en = 1'b0;
      chk("R9", "reserved strobes", {6'b0, wr_file, wr_wreg}, 8'h00);
      chk("R9", "reserved result", res_val, exp_res);
      chk("R9", "reserved flags", {3'b0, flags}, {3'b0, exp_flags});
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule